// File: doc/BRIEF.md
# Store-Multiple Bus Cycle Sequencer

This block drives the memory bus for one block-store instruction. A start strobe latches the program counter, a computed base address and a register mask of up to sixteen bits. The block then runs a fixed shape of bus cycles. First comes an opcode prefetch at pc+8. Then there is one word write for each register named in the mask, in ascending register number, at consecutive word addresses that begin at the base address. The block selects each register through a combinational read port and drives that register's value onto the write data bus in the same cycle.

The last write is not followed by any idle internal cycle. In the very next cycle the block presents the hand-back opcode fetch at pc+12 and pulses `done`. An abort seen on any write cycle does not shorten the sequence. It is recorded and reported on `aborted`, which the block holds until the next start. An empty mask behaves as a single store of the highest register. Decoding, base writeback and exception entry belong to other logic.

Top module: `stm_bus_seq`

## Requirements
- R1: After reset, `mem_req`, `bus_write`, `opcode_fetch`, `seq`, `done` and `aborted` are all 0 and `bus_addr` is 0.
- R2: In the cycle after `start` is sampled in idle, the bus shows an opcode fetch at pc+8: `opcode_fetch`=1, `bus_write`=0, `seq`=0, `mem_req`=1.
- R3: The cycle after the prefetch is a write (`bus_write`=1, `opcode_fetch`=0) at the base address. On it, `wdata` equals the read-port value of the lowest-numbered register in the mask.
- R4: Each further write cycle follows directly and has an address 4 above the previous one. Registers go out in strictly ascending number, one per set mask bit, with `wdata` equal to the selected register's value.
- R5: `seq` is 1 on every write cycle except the final one, where it is 0. A one-register store therefore has `seq`=0 on its only write.
- R6: `bus_word` is 1 on every cycle, and `mem_req` is 1 on the prefetch and on every write cycle.
- R7: The cycle right after the final write presents a fetch at pc+12 (`opcode_fetch`=1, `mem_req`=1, `bus_write`=0), and `done` is 1 for exactly that one cycle. The fetch stays on the bus until the next start.
- R8: `abort` high on any write cycle does not stop or change the write sequence. `aborted` reads 1 from the `done` cycle until the next start, which clears it. `abort` outside write cycles is ignored.
- R9: A zero register mask gives exactly one write, of register 15, with `seq`=0.
- R10: `start` while a sequence is in progress is ignored. The addresses, data and length of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a store sequence (sampled in idle only) |
| pc | input | 32 | Program counter of the store instruction |
| base_addr | input | 32 | First write address |
| reg_mask | input | 16 | Registers to store, bit i = register i |
| rd_sel | output | 4 | Register read-port select |
| rd_data | input | 32 | Value of the selected register (combinational) |
| abort | input | 1 | Memory abort for the current write cycle |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | 1 = write cycle, 0 = read |
| bus_word | output | 1 | 1 = word transfer |
| mem_req | output | 1 | Memory request |
| seq | output | 1 | Next cycle continues at the following word address |
| opcode_fetch | output | 1 | Cycle is an instruction fetch |
| wdata | output | 32 | Write data (0 outside write cycles) |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Sticky abort status of the last sequence |

## Verification
The prefetch appears one cycle after the edge that samples `start`. The first write follows two cycles after that edge, and write k follows k+1 cycles after it. The pc+12 fetch and the `done` pulse come one cycle after the last write. Each scenario task raises `start` at a falling edge and then samples every bus signal at each later falling edge, so each check reads a value that is settled and belongs to a known cycle of the sequence. Aborts and stray starts are driven at falling edges in chosen cycles. Their effect, or the absence of one, is checked on the cycles that follow.

// File: rtl/stm_bus_seq.sv
module stm_bus_seq #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   pc,
  input  logic [AW-1:0]   base_addr,
  input  logic [NREG-1:0] reg_mask,
  output logic [IW-1:0]   rd_sel,
  input  logic [DW-1:0]   rd_data,
  input  logic            abort,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_write,
  output logic            bus_word,
  output logic            mem_req,
  output logic            seq,
  output logic            opcode_fetch,
  output logic [DW-1:0]   wdata,
  output logic            done,
  output logic            aborted
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE} st_t;

  st_t             st;
  logic [AW-1:0]   pc_q, addr_q;
  logic [NREG-1:0] rem_q;
  logic            handoff_q, done_q, abt_q;
  logic [IW-1:0]   cur_idx;
  logic            last;

  always_comb begin
    cur_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) cur_idx = IW'(i);
  end

  assign last = (rem_q & (rem_q - 1'b1)) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pc_q      <= '0;
      addr_q    <= '0;
      rem_q     <= '0;
      handoff_q <= 1'b0;
      done_q    <= 1'b0;
      abt_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_FETCH;
          pc_q      <= pc;
          addr_q    <= base_addr;
          rem_q     <= (reg_mask == '0) ? NREG'(1) << (NREG - 1) : reg_mask;
          abt_q     <= 1'b0;
          handoff_q <= 1'b0;
        end
        S_FETCH: st <= S_WRITE;
        S_WRITE: begin
          rem_q  <= rem_q & (rem_q - 1'b1);
          addr_q <= addr_q + AW'(4);
          if (abort) abt_q <= 1'b1;
          if (last) begin
            st        <= S_IDLE;
            done_q    <= 1'b1;
            handoff_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_write    = (st == S_WRITE);
  assign opcode_fetch = (st == S_FETCH) || (st == S_IDLE && handoff_q);
  assign mem_req      = (st != S_IDLE) || handoff_q;
  assign bus_word     = 1'b1;
  assign seq          = bus_write && !last;
  assign rd_sel       = cur_idx;
  assign wdata        = bus_write ? rd_data : '0;
  assign done         = done_q;
  assign aborted      = abt_q;

  always_comb begin
    case (st)
      S_FETCH: bus_addr = pc_q + AW'(8);
      S_WRITE: bus_addr = addr_q;
      default: bus_addr = handoff_q ? pc_q + AW'(12) : '0;
    endcase
  end

  p_write_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_write) |-> $past(opcode_fetch) && !opcode_fetch);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && $past(bus_write)) |-> bus_addr == $past(bus_addr) + AW'(4));

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && $past(bus_write)) |-> rd_sel > $past(rd_sel));

  p_seq_continues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && seq) |=> bus_write);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && !seq) |=> (!bus_write && done && opcode_fetch));

  p_req_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> mem_req);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(aborted) && !$past(start)) |-> aborted);

endmodule

// File: tb/stm_bus_seq_test.sv
module stm_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pc = '0, base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [3:0]  rd_sel;
  logic [31:0] rd_data;
  logic        abort = 1'b0;
  logic [31:0] bus_addr, wdata;
  logic        bus_write, bus_word, mem_req, seq, opcode_fetch, done, aborted;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign rd_data = {16'hC0DE, 12'h000, rd_sel};

  stm_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .base_addr(base_addr),
    .reg_mask(reg_mask), .rd_sel(rd_sel), .rd_data(rd_data), .abort(abort),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_word(bus_word),
    .mem_req(mem_req), .seq(seq), .opcode_fetch(opcode_fetch), .wdata(wdata),
    .done(done), .aborted(aborted)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    chk(mem_req == 0 && bus_write == 0 && opcode_fetch == 0 && seq == 0, "R1 bus idle",
        {28'd0, mem_req, bus_write, opcode_fetch, seq}, 32'd0);
    chk(done == 0 && aborted == 0, "R1 status", {30'd0, done, aborted}, 32'd0);
    chk(bus_addr == 0, "R1 addr", bus_addr, 32'd0);
  endtask

  // abort_at: write index to raise abort on (-1 none); poke: stray start during prefetch
  task automatic run_seq(input logic [15:0] m, input logic [31:0] pcv, input logic [31:0] bv,
                         input int abort_at, input bit poke, input bit abort_in_fetch);
    int regs[$];
    logic [15:0] em;
    em = (m == 0) ? 16'h8000 : m;
    for (int i = 0; i < 16; i++) if (em[i]) regs.push_back(i);
    @(negedge clk);
    start = 1; pc = pcv; base_addr = bv; reg_mask = m;
    @(negedge clk);
    start = 0;
    chk(bus_addr == pcv + 8, "R2 prefetch addr", bus_addr, pcv + 8);
    chk(opcode_fetch && !bus_write && !seq && mem_req && bus_word, "R2/R6 prefetch ctl",
        {27'd0, opcode_fetch, bus_write, seq, mem_req, bus_word}, 32'b10011);
    if (poke) begin
      start = 1; pc = 32'h5555_0000; base_addr = 32'h7777_0000; reg_mask = 16'h0001;
    end
    if (abort_in_fetch) abort = 1;
    for (int k = 0; k < regs.size(); k++) begin
      @(negedge clk);
      start = 0; abort = 0;
      chk(bus_write && !opcode_fetch && mem_req && bus_word, k == 0 ? "R3 first write ctl" : "R6 write ctl",
          {28'd0, bus_write, opcode_fetch, mem_req, bus_word}, 32'b1011);
      chk(bus_addr == bv + 4 * k, k == 0 ? "R3 base addr" : (poke ? "R10 addr" : "R4 addr step"),
          bus_addr, bv + 4 * k);
      chk(wdata == {16'hC0DE, 12'h000, 4'(regs[k])}, m == 0 ? "R9 r15 data" : "R4 order/data",
          wdata, {16'hC0DE, 12'h000, 4'(regs[k])});
      chk(seq == (k != regs.size() - 1), m == 0 ? "R9 seq" : "R5 seq", {31'd0, seq},
          {31'd0, k != regs.size() - 1});
      if (k == abort_at) abort = 1;
    end
    @(negedge clk);
    abort = 0;
    chk(!bus_write && opcode_fetch && mem_req && bus_addr == pcv + 12, "R7 handoff fetch",
        bus_addr, pcv + 12);
    chk(done, "R7 done", {31'd0, done}, 32'd1);
    chk(aborted == (abort_at >= 0), "R8 aborted", {31'd0, aborted}, {31'd0, abort_at >= 0});
    @(negedge clk);
    chk(!done && opcode_fetch && bus_addr == pcv + 12, "R7 done one cycle, fetch held",
        {31'd0, done}, 32'd0);
    chk(aborted == (abort_at >= 0), "R8 aborted held", {31'd0, aborted}, {31'd0, abort_at >= 0});
  endtask

  task automatic t_single();  run_seq(16'h0010, 32'h0000_1000, 32'h0000_8000, -1, 0, 0); endtask
  task automatic t_multi();   run_seq(16'h80A5, 32'h0000_2000, 32'h0001_0000, -1, 0, 0); endtask
  task automatic t_full();    run_seq(16'hFFFF, 32'h0000_3000, 32'h0002_0040, -1, 0, 0); endtask
  task automatic t_empty();   run_seq(16'h0000, 32'h0000_4000, 32'h0003_0000, -1, 0, 0); endtask
  task automatic t_abort();   run_seq(16'h0E00, 32'h0000_5000, 32'h0004_0000,  1, 0, 0); endtask
  task automatic t_busy();    run_seq(16'h0006, 32'h0000_6000, 32'h0005_0000, -1, 1, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_reset();
    t_single();
    t_multi();
    t_full();
    t_empty();
    t_abort();
    t_multi();   // R8: new start clears the abort status
    t_busy();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule